// File: doc/BRIEF.md
# Transmit-only serial byte streamer

The streamer sends the contents of a small byte memory, one bit per rising edge of an external clock, through a data pin modelled as an output-enable plus data pair. It is the free-running output path of a device that starts up in a listen-free, send-only state. A mode controller selects it, and the memory is read one byte at a time through a simple read port.

After reset the pin stays released for a quiet lead-in of nine clocks. After the lead-in the block sends byte frames. Each frame is nine clocks long: eight data bits, most significant first, then a separator bit driven high. Addresses run from zero upward and wrap to zero after the last one.

When the mode input drops, the pin is released and the frame position is held, so streaming resumes exactly where it stopped. A restart pulse returns the block to address zero at the start of a frame. The first bit then follows on the next edge, with no new lead-in.

Top module: `tx_only_streamer`

## Requirements
- R1: After reset, with `mode_tx_i`=1, `sda_oe_o` stays 0 for the first 9 rising edges of `clk_i`. On the 10th such edge it goes to 1 and `sda_o` carries bit 7 of the byte at address 0. Edges with `mode_tx_i`=0 do not count toward the nine.
- R2: `mem_addr_o` is 0 at the start and the read data on `mem_rdata_i` is taken in the same cycle. The address rises by one after each full frame.
- R3: A frame occupies 9 consecutive driven edges. The first eight edges carry `mem_rdata_i` bits 7 down to 0, in that order. The ninth edge carries a separator bit with `sda_o`=1.
- R4: The frame that follows the byte at address DEPTH-1 is read from address 0. Every address is sent in turn.
- R5: At an edge where `mode_tx_i`=0, `sda_oe_o` goes to 0 and the address, bit position and lead-in count are all held. When the mode returns, the next driven bit is the one that was due.
- R6: At an edge where `restart_i`=1, `sda_oe_o` goes to 0 and the address and bit position return to 0, whatever the mode. At the next edge with `mode_tx_i`=1, bit 7 of address 0 is driven without any lead-in.
- R7: `driving_o` always equals `sda_oe_o`. `sda_o` is 1 whenever `sda_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | External bit clock; all state moves on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| restart_i | input | 1 | Synchronous restart to address 0, frame start |
| mode_tx_i | input | 1 | 1 selects transmit-only mode |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_rdata_i | input | 8 | Byte read at `mem_addr_o`, same cycle |
| sda_oe_o | output | 1 | 1 drives the data pin, 0 releases it |
| sda_o | output | 1 | Data level while driven |
| driving_o | output | 1 | High while the pin is driven |

## Verification
The faults that matter here are a bad bit position or a bad address. A wrong bit position shows on `sda_o` within a single driven edge: either a separator bit appears inside a byte, or a data bit lands where the separator belongs. A wrong address shows on `mem_addr_o` at once. Its effect on the serial stream appears at the next frame boundary, and a missed wrap is only visible after DEPTH frames. A lead-in count that is wrong by one shifts the first driven edge by a cycle, so the bench checks enable, data and address after every edge against its own model of the frame.

// File: rtl/tx_stream_pkg.sv
package tx_stream_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned FRAME_LEN = DATA_W + 1;
  localparam int unsigned PRE_LEN   = 9;
  localparam int unsigned POS_W     = $clog2(FRAME_LEN);

  typedef logic [POS_W-1:0] pos_t;

  // bit for frame position p (0 = msb); caller handles the separator slot
  function automatic logic pick_bit(input logic [DATA_W-1:0] d, input pos_t p);
    logic [2:0] idx;
    idx = 3'(DATA_W - 1) - p[2:0];
    return d[idx];
  endfunction
endpackage

// File: rtl/tx_preamble.sv
module tx_preamble #(
  parameter int unsigned LEN = tx_stream_pkg::PRE_LEN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic skip_i,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (skip_i) begin
      done_q <= 1'b1;
    end else if (step_i && !done_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) done_q <= 1'b1;
    end
  end

  assign done_o = done_q;

  a_r1_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> cnt_q <= LAST);
endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import tx_stream_pkg::*;
#(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              restart_i,
  output pos_t              pos_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sep_o
);
  localparam pos_t              POS_LAST  = pos_t'(FRAME_LEN - 1);
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(DEPTH - 1);

  pos_t              pos_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      addr_q <= '0;
    end else if (restart_i) begin
      pos_q  <= '0;
      addr_q <= '0;
    end else if (adv_i) begin
      if (pos_q == POS_LAST) begin
        pos_q  <= '0;
        addr_q <= (addr_q == ADDR_LAST) ? '0 : addr_q + 1'b1;
      end else begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  assign pos_o  = pos_q;
  assign addr_o = addr_q;
  assign sep_o  = (pos_q == POS_LAST);

  a_r2_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !restart_i && sep_o && addr_q != ADDR_LAST |=> addr_o == $past(addr_q) + 1'b1);
  a_r4_addr_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !restart_i && sep_o && addr_q == ADDR_LAST |=> addr_o == '0);
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !restart_i |=> $stable(addr_o) && $stable(pos_o));
  a_r6_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> addr_o == '0 && pos_o == '0);
endmodule

// File: rtl/tx_out_stage.sv
module tx_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_i,
  output logic oe_o,
  output logic dat_o
);
  logic oe_q, dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q  <= 1'b0;
      dat_q <= 1'b1;
    end else begin
      oe_q  <= en_i;
      dat_q <= en_i ? bit_i : 1'b1;
    end
  end

  assign oe_o  = oe_q;
  assign dat_o = dat_q;

  a_r7_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> dat_o);
endmodule

// File: rtl/tx_only_streamer.sv
module tx_only_streamer
  import tx_stream_pkg::*;
#(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              mode_tx_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              sda_oe_o,
  output logic              sda_o,
  output logic              driving_o
);
  logic pre_done, adv, sep, tx_bit;
  pos_t pos;

  tx_preamble #(.LEN(PRE_LEN)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (mode_tx_i),
    .skip_i (restart_i),
    .done_o (pre_done)
  );

  assign adv = mode_tx_i && pre_done && !restart_i;

  tx_frame_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .restart_i (restart_i),
    .pos_o     (pos),
    .addr_o    (mem_addr_o),
    .sep_o     (sep)
  );

  assign tx_bit = sep ? 1'b1 : pick_bit(mem_rdata_i, pos);

  tx_out_stage u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (adv),
    .bit_i  (tx_bit),
    .oe_o   (sda_oe_o),
    .dat_o  (sda_o)
  );

  assign driving_o = sda_oe_o;

  a_r1_quiet_lead_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pre_done |=> !sda_oe_o);
  a_r3_separator_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_tx_i && pre_done && !restart_i && sep |=> sda_oe_o && sda_o);
  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_tx_i |=> !sda_oe_o);
  a_r6_restart_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !sda_oe_o);
endmodule

// File: tb/tx_only_streamer_tb_top.sv
module tx_only_streamer_tb_top;
  localparam int DEPTH  = 128;
  localparam int ADDR_W = 7;
  localparam time CLK_PERIOD = 20ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic restart = 1'b0;
  logic mode = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_rdata;
  logic oe, sda, drv;

  int checks = 0;
  int errors = 0;

  // expected state
  int e_pre, e_pos, e_addr;
  logic e_oe, e_sda;
  string e_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_fn(input int a);
    return 8'((a * 37 + 91) % 256);
  endfunction

  always_comb mem_rdata = mem_fn(int'(mem_addr));

  tx_only_streamer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .restart_i(restart), .mode_tx_i(mode),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .sda_oe_o(oe), .sda_o(sda), .driving_o(drv)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    e_pre = 0; e_pos = 0; e_addr = 0; e_oe = 0; e_sda = 1; e_tag = "R1";
  endtask

  // one edge with given inputs, model update, compare at negedge
  task automatic cyc(input logic m, input logic r);
    mode = m; restart = r;
    @(posedge clk);
    if (r) begin
      e_addr = 0; e_pos = 0; e_pre = 9; e_oe = 0; e_sda = 1; e_tag = "R6";
    end else if (!m) begin
      e_oe = 0; e_sda = 1; e_tag = "R5";
    end else if (e_pre < 9) begin
      e_pre++; e_oe = 0; e_sda = 1; e_tag = "R1";
    end else begin
      e_oe = 1;
      if (e_pos == 8) begin
        e_sda = 1; e_tag = (e_addr == DEPTH-1) ? "R4" : "R3";
        e_pos = 0; e_addr = (e_addr == DEPTH-1) ? 0 : e_addr + 1;
      end else begin
        e_sda = mem_fn(e_addr)[7-e_pos]; e_tag = "R3"; e_pos++;
      end
    end
    @(negedge clk);
    check({e_tag, " oe"}, int'(oe), int'(e_oe));
    check({e_tag, " sda"}, int'(sda), int'(e_sda));
    check("R2 addr", int'(mem_addr), e_addr);
    check("R7 driving", int'(drv), int'(oe));
  endtask

  // segments: {mode, restart, edges}
  localparam int NSEG = 8;
  localparam logic [9:0] SEG [NSEG] = '{
    {1'b1, 1'b0, 8'd40}, {1'b0, 1'b0, 8'd5}, {1'b1, 1'b0, 8'd30}, {1'b1, 1'b1, 8'd1},
    {1'b1, 1'b0, 8'd25}, {1'b0, 1'b1, 8'd1}, {1'b0, 1'b0, 8'd3},  {1'b1, 1'b0, 8'd20}
  };

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk); @(negedge clk);
    // R1 R7 reset state
    check("R1 reset oe", int'(oe), 0);
    check("R7 reset sda", int'(sda), 1);
    check("R7 reset driving", int'(drv), 0);
    check("R2 reset addr", int'(mem_addr), 0);
    rst_ni = 1'b1;

    for (int s = 0; s < NSEG; s++)
      for (int k = 0; k < int'(SEG[s][7:0]); k++)
        cyc(SEG[s][9], SEG[s][8]);

    // mid-run reset, then lead-in split by a mode drop (R1, R5)
    rst_ni = 1'b0; #1;
    model_reset();
    check("R1 async reset oe", int'(oe), 0);
    @(negedge clk); rst_ni = 1'b1;
    for (int k = 0; k < 4; k++) cyc(1'b1, 1'b0);
    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0);
    for (int k = 0; k < 5; k++) cyc(1'b1, 1'b0);
    check("R1 still quiet after 9", int'(oe), 0);
    cyc(1'b1, 1'b0);
    check("R1 first bit oe", int'(oe), 1);
    check("R1 first bit D7", int'(sda), int'(mem_fn(0)[7]));

    // restart then full wrap (R6, R4)
    cyc(1'b1, 1'b1);
    cyc(1'b1, 1'b0);
    check("R6 no lead-in", int'(oe), 1);
    for (int k = 1; k < 127 * 9; k++) cyc(1'b1, 1'b0);
    check("R4 last addr", int'(mem_addr), DEPTH - 1);
    for (int k = 0; k < 9; k++) cyc(1'b1, 1'b0);
    check("R4 wrapped addr", int'(mem_addr), 0);
    cyc(1'b1, 1'b0);
    check("R4 wrap byte D7", int'(sda), int'(mem_fn(0)[7]));
    for (int k = 0; k < 20; k++) cyc(1'b1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule